// File: doc/BRIEF.md
# MDIO Management Controller

This block runs one Clause 22 management transaction at a time toward an external PHY. Software talks to it through a small 16-bit register port. For a write, software first loads the data word and then the command word. For a read, it writes the command word alone. The command write starts the frame on its own. The block then makes the management clock from the system clock, shifts the frame out on a tri-state data line, and reports progress through a busy flag. For a read, it collects the PHY's answer into the data register.

A self-control register selects the clock divider, which is stored as the divisor minus one. The same register has an option that drops the 32-bit preamble for PHYs that accept short frames. It also holds a soft-reset bit that clears itself. Register addresses are: 0 self-control, 1 command, 2 data, 3 status.

Top module: `mdio_ctrl`

## Requirements
- R1: After reset, all four registers read 0, `mdc` is low and `mdio_oe` is low.
- R2: Writing the command register starts a transaction as follows. Bit 15 set starts a read. Bit 14 set (with bit 15 clear) starts a write. If both bits are set, the read wins. If neither is set, no transaction starts. Status bit 0 reads 1 from the cycle after the accepted command write until the frame ends.
- R3: The frame is sent MSB first, one bit per `mdc` period, in this order:
  - 32 ones, left out when self-control bit 8 is 1;
  - start code 01;
  - opcode 10 for a read, 01 for a write;
  - PHY address from command bits 9:5;
  - register number from command bits 4:0;
  - turnaround, 10 for a write;
  - 16 data bits taken from the data register.
- R4: Self-control bits 15:9 hold the divisor minus one, with a value of 0 treated as 1. Each `mdc` period lasts (field+1) system clocks, and `mdc` is high for floor((field+1)/2) of them. `mdc` stays low while the block is idle.
- R5: `mdio_o` changes only on a falling edge of `mdc`. In a read, `mdio_oe` is 0 for the turnaround and all 16 data bits.
- R6: A read captures `mdio_i` on each rising `mdc` edge of the 16 data bits, MSB first. The result is in the data register once busy clears.
- R7: While busy, writes to the command register, the data register and the divisor/suppress fields are ignored.
- R8: Writing self-control bit 0 as 1 does the following:
  - it aborts any frame, so busy is 0 one cycle later;
  - it clears the data, command, divisor and suppress fields;
  - bit 0 then reads 1 for exactly SRST_CYCLES cycles after the write and returns to 0 by itself;
  - all register writes made during that window are ignored.
- R9: Status reads busy in bit 0 and zeros elsewhere. The command register reads back the last accepted command word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational on address) |
| mdc | output | 1 | Management clock to PHY |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in from pad |

## Verification
The hardest situations to reach from the ports are register writes that land inside a live frame, and a soft reset that cuts a read in half. The stimulus sets a slow divisor so that a frame lasts hundreds of cycles. It then issues conflicting command, data and divisor writes while busy is set. Afterwards it checks that exactly one frame's worth of clock edges occurred and that every register kept its value. For the reset case, it starts a read, lets it run for some cycles, and then sets the reset bit. It reads the bit back on the last cycle it should still be set and on the first cycle it should be clear. It also sends a data write inside the reset window and confirms that the write was lost.

// File: rtl/mdio_ctrl_pkg.sv
package mdio_ctrl_pkg;
  localparam logic [1:0] A_SELF = 2'd0;
  localparam logic [1:0] A_CMD  = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;

  localparam int CMD_RD_BIT  = 15;
  localparam int CMD_WR_BIT  = 14;
  localparam int SC_RST_BIT  = 0;
  localparam int SC_SUPP_BIT = 8;
  localparam int SC_DIV_LSB  = 9;

  localparam int FRAME_BITS = 64;
  localparam int SHORT_BITS = 32;
  localparam int DATA_BITS  = 16;
  localparam int TAIL_BITS  = DATA_BITS + 2;

  typedef struct packed {
    logic [1:0]  st;
    logic [1:0]  op;
    logic [4:0]  phy;
    logic [4:0]  regn;
    logic [1:0]  ta;
    logic [15:0] dat;
  } mdio_frame_t;

  function automatic mdio_frame_t make_frame(input logic rd, input logic [4:0] phy,
                                             input logic [4:0] regn, input logic [15:0] d);
    mdio_frame_t f;
    f.st   = 2'b01;
    f.op   = rd ? 2'b10 : 2'b01;
    f.phy  = phy;
    f.regn = regn;
    f.ta   = rd ? 2'b11 : 2'b10;
    f.dat  = rd ? 16'hFFFF : d;
    return f;
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_m1,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);
  logic [DIV_W-1:0] eff, half, cnt_q, cnt_n;
  logic [DIV_W:0]   per;
  logic             mdc_q, mdc_n;

  assign eff  = (div_m1 == '0) ? DIV_W'(1) : div_m1;
  assign per  = {1'b0, eff} + (DIV_W+1)'(1);
  assign half = per[DIV_W:1];

  assign rise_tick = run && (cnt_q == eff);
  assign fall_tick = run && (cnt_q == half - DIV_W'(1));
  assign mdc       = mdc_q;

  always_comb begin
    cnt_n = cnt_q;
    mdc_n = mdc_q;
    if (!run) begin
      cnt_n = half;
      mdc_n = 1'b0;
    end else if (rise_tick) begin
      cnt_n = '0;
      mdc_n = 1'b1;
    end else begin
      cnt_n = cnt_q + DIV_W'(1);
      if (fall_tick) mdc_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= DIV_W'(1);
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      mdc_q <= mdc_n;
    end
  end
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
  import mdio_ctrl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        abort,
  input  logic        start,
  input  logic        start_rd,
  input  logic [4:0]  phy,
  input  logic [4:0]  regn,
  input  logic [15:0] wdat,
  input  logic        supp,
  input  logic        rise_tick,
  input  logic        fall_tick,
  input  logic        mdio_i,
  output logic        busy,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        rd_done,
  output logic [15:0] rd_data
);
  logic                  busy_q, busy_n, rd_q, rd_n, oe_q, oe_n;
  logic [FRAME_BITS-1:0] sh_q, sh_n;
  logic [5:0]            rem_q, rem_n, rem_dec;
  logic [15:0]           cap_q, cap_n;
  mdio_frame_t           frm;

  assign frm     = make_frame(start_rd, phy, regn, wdat);
  assign rem_dec = rem_q - 6'd1;
  assign busy    = busy_q;
  assign mdio_o  = sh_q[FRAME_BITS-1];
  assign mdio_oe = oe_q;
  assign rd_data = cap_q;
  assign rd_done = busy_q && !abort && fall_tick && (rem_q == 6'd0) && rd_q;

  always_comb begin
    busy_n = busy_q;
    rd_n   = rd_q;
    oe_n   = oe_q;
    sh_n   = sh_q;
    rem_n  = rem_q;
    cap_n  = cap_q;
    if (abort) begin
      busy_n = 1'b0;
      oe_n   = 1'b0;
    end else if (!busy_q) begin
      if (start) begin
        busy_n = 1'b1;
        oe_n   = 1'b1;
        rd_n   = start_rd;
        sh_n   = supp ? {frm, 32'h0} : {32'hFFFF_FFFF, frm};
        rem_n  = supp ? 6'(SHORT_BITS - 1) : 6'(FRAME_BITS - 1);
      end
    end else begin
      if (rise_tick && rd_q && (rem_q < 6'(DATA_BITS)))
        cap_n = {cap_q[14:0], mdio_i};
      if (fall_tick) begin
        if (rem_q == 6'd0) begin
          busy_n = 1'b0;
          oe_n   = 1'b0;
        end else begin
          sh_n  = {sh_q[FRAME_BITS-2:0], 1'b0};
          rem_n = rem_dec;
          oe_n  = !(rd_q && (rem_dec < 6'(TAIL_BITS)));
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      oe_q   <= 1'b0;
      sh_q   <= '0;
      rem_q  <= '0;
      cap_q  <= '0;
    end else begin
      busy_q <= busy_n;
      rd_q   <= rd_n;
      oe_q   <= oe_n;
      sh_q   <= sh_n;
      rem_q  <= rem_n;
      cap_q  <= cap_n;
    end
  end
endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_ctrl_pkg::*;
#(
  parameter int DIV_W       = 7,
  parameter int SRST_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int SR_W = $clog2(SRST_CYCLES + 1);

  logic [DIV_W-1:0] div_q, div_n;
  logic             supp_q, supp_n;
  logic [SR_W-1:0]  srst_q, srst_n;
  logic [15:0]      data_q, data_n, cmd_q, cmd_n, rd_data;
  logic             srst_active, busy, open_wr, cmd_start, rd_done;
  logic             rise_tick, fall_tick;
  logic [15:0]      sc_word;
  logic             unused_wdata;

  assign unused_wdata = ^reg_wdata;
  assign srst_active  = (srst_q != '0);
  assign open_wr      = !busy && !srst_active;
  assign cmd_start    = reg_we && (reg_addr == A_CMD) && open_wr &&
                        (reg_wdata[CMD_RD_BIT] || reg_wdata[CMD_WR_BIT]);

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy), .div_m1(div_q),
    .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_engine u_eng (
    .clk(clk), .rst_n(rst_n), .abort(srst_active), .start(cmd_start),
    .start_rd(reg_wdata[CMD_RD_BIT]), .phy(reg_wdata[9:5]), .regn(reg_wdata[4:0]),
    .wdat(data_q), .supp(supp_q), .rise_tick(rise_tick), .fall_tick(fall_tick),
    .mdio_i(mdio_i), .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .rd_done(rd_done), .rd_data(rd_data)
  );

  always_comb begin
    div_n  = div_q;
    supp_n = supp_q;
    data_n = data_q;
    cmd_n  = cmd_q;
    srst_n = srst_active ? srst_q - SR_W'(1) : srst_q;
    if (rd_done) data_n = rd_data;
    if (reg_we && !srst_active) begin
      unique case (reg_addr)
        A_SELF: begin
          if (reg_wdata[SC_RST_BIT]) begin
            srst_n = SR_W'(SRST_CYCLES);
            div_n  = '0;
            supp_n = 1'b0;
            data_n = '0;
            cmd_n  = '0;
          end else if (!busy) begin
            div_n  = reg_wdata[SC_DIV_LSB +: DIV_W];
            supp_n = reg_wdata[SC_SUPP_BIT];
          end
        end
        A_CMD:   if (!busy) cmd_n = reg_wdata;
        A_DATA:  if (!busy) data_n = reg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    sc_word                          = '0;
    sc_word[SC_DIV_LSB +: DIV_W]     = div_q;
    sc_word[SC_SUPP_BIT]             = supp_q;
    sc_word[SC_RST_BIT]              = srst_active;
    unique case (reg_addr)
      A_SELF:  reg_rdata = sc_word;
      A_CMD:   reg_rdata = cmd_q;
      A_DATA:  reg_rdata = data_q;
      default: reg_rdata = {15'd0, busy};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      supp_q <= 1'b0;
      srst_q <= '0;
      data_q <= '0;
      cmd_q  <= '0;
    end else begin
      div_q  <= div_n;
      supp_q <= supp_n;
      srst_q <= srst_n;
      data_q <= data_n;
      cmd_q  <= cmd_n;
    end
  end
endmodule

// File: rtl/mdio_ctrl_chk.sv
module mdio_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe,
  input logic busy,
  input logic srst_active,
  input logic cmd_start
);
  // R4: management clock idles low
  a_r4_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  // R5: data line is only driven inside a frame
  a_r5_drive_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> busy);

  // R5: inside a frame the data bit moves only with a falling MDC edge
  a_r5_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(mdio_o)) |-> $fell(mdc));

  // R2: a frame begins only from an accepted command write
  a_r2_start_from_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_start));

  // R8: soft reset keeps the engine idle
  a_r8_reset_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_active && $past(srst_active)) |-> !busy);
endmodule

bind mdio_ctrl mdio_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .busy(busy), .srst_active(srst_active), .cmd_start(cmd_start)
);

// File: tb/mdio_ctrl_test.sv
module mdio_ctrl_test;
  localparam logic [1:0] SELF = 2'd0, CMD = 2'd1, DATA = 2'd2, STAT = 2'd3;

  logic        clk, rst_n, reg_we, mdc, mdio_o, mdio_oe, phy_bit;
  logic [1:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;

  mdio_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(phy_bit)
  );

  int checks = 0, fails = 0, cyc = 0;
  int nr = 0, phy_total = 64, per = 0, hi = 0, last_rise = 0, bad_edge = 0;
  logic cap_o [64];
  logic cap_oe[64];
  logic [15:0] phy_val = 16'h0;
  logic prev_mdc = 1'b0, prev_o = 1'b0, prev_oe = 1'b0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL R2 watchdog expired actual=%0d expected=<150000", cyc);
      summary();
      $finish;
    end
  end

  // PHY model: record the line on each rising MDC, present read data after each fall
  always @(posedge mdc) begin
    if (nr < 64) begin cap_o[nr] = mdio_o; cap_oe[nr] = mdio_oe; end
    nr++;
  end
  always @(negedge mdc) begin
    if (nr >= phy_total - 16 && nr < phy_total) phy_bit = phy_val[15 - (nr - (phy_total - 16))];
    else phy_bit = 1'b1;
  end

  always @(negedge clk) begin
    if (mdc && !prev_mdc) begin per = cyc - last_rise; last_rise = cyc; end
    if (!mdc && prev_mdc) hi = cyc - last_rise;
    if (mdio_oe && prev_oe && (mdio_o != prev_o) && !(prev_mdc && !mdc)) bad_edge++;
    prev_mdc = mdc; prev_o = mdio_o; prev_oe = mdio_oe;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    do begin @(negedge clk); rd(STAT, s); end while (s[0]);
  endtask

  task automatic arm(input int total, input logic [15:0] v);
    nr = 0; phy_total = total; phy_val = v; phy_bit = 1'b1; bad_edge = 0;
  endtask

  task automatic txn(input bit is_rd, input logic [4:0] phy, input logic [4:0] rg,
                     input logic [15:0] val, input bit supp, input int divf);
    logic [15:0] s;
    logic [31:0] f;
    logic [63:0] w;
    int eff, total, bad;
    bit exp_oe;
    wr(SELF, 16'((divf << 9) | (int'(supp) << 8)));
    if (!is_rd) wr(DATA, val);
    eff   = (divf == 0) ? 1 : divf;
    total = supp ? 32 : 64;
    arm(total, val);
    wr(CMD, {is_rd, !is_rd, 4'b0, phy, rg});
    rd(STAT, s);
    chk(s[0] == 1'b1, "R2", "busy after command", s[0], 1);
    wait_idle();
    chk(nr == total, "R3", "MDC rising edges per frame", nr, total);
    f = {2'b01, (is_rd ? 2'b10 : 2'b01), phy, rg, (is_rd ? 2'b11 : 2'b10), val};
    w = supp ? {f, 32'h0} : {32'hFFFF_FFFF, f};
    bad = 0;
    for (int k = 0; k < total; k++) begin
      exp_oe = !(is_rd && k >= total - 18);
      if (cap_oe[k] != exp_oe) bad++;
      else if (exp_oe && cap_o[k] != w[63 - k]) bad++;
    end
    chk(bad == 0, "R3 R5", "frame bit / drive mismatches", bad, 0);
    chk(per == eff + 1, "R4", "MDC period", per, eff + 1);
    chk(hi == (eff + 1) / 2, "R4", "MDC high time", hi, (eff + 1) / 2);
    chk(bad_edge == 0, "R5", "data changes off falling MDC", bad_edge, 0);
    chk(!mdc && !mdio_oe, "R4", "idle MDC/oe", {mdc, mdio_oe}, 0);
    rd(DATA, s);
    chk(s == val, is_rd ? "R6" : "R3", "data register after frame", s, val);
    rd(CMD, s);
    chk(s == {is_rd, !is_rd, 4'b0, phy, rg}, "R9", "command readback", s, {is_rd, !is_rd, 4'b0, phy, rg});
  endtask

  initial begin
    logic [15:0] v;
    int divs[7] = '{0, 1, 2, 3, 5, 8, 127};
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; phy_bit = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk(v == 16'h0, "R1", "register after reset", v, 0);
    end
    chk(!mdc && !mdio_oe, "R1", "mdc/oe after reset", {mdc, mdio_oe}, 0);

    // R2: command with neither opcode bit does nothing
    arm(64, 16'h0);
    wr(CMD, 16'h0123);
    rd(STAT, v);
    chk(v == 16'h0, "R2", "status after no-op command", v, 0);
    repeat (20) @(negedge clk);
    chk(nr == 0, "R2", "MDC edges after no-op command", nr, 0);
    rd(CMD, v);
    chk(v == 16'h0123, "R9", "no-op command readback", v, 16'h0123);

    // Sweep: divisors x preamble mode x direction
    foreach (divs[i]) begin
      for (int sp = 0; sp < 2; sp++) begin
        if (divs[i] == 127 && sp == 0) continue;
        for (int r = 0; r < 2; r++)
          txn(r[0], 5'(3 * i + sp + 1), 5'(31 - 2 * i - r),
              16'hA5C3 ^ 16'(i * 16'h1357) ^ 16'(sp * 16'h0F0F) ^ 16'(r * 16'h8001),
              sp[0], divs[i]);
      end
    end

    // R2: both opcode bits set gives a read
    wr(SELF, 16'h0100);
    arm(32, 16'h3C5A);
    wr(CMD, 16'hC000 | 16'(5'd7 << 5) | 16'd9);
    wait_idle();
    chk({cap_o[2], cap_o[3]} == 2'b10, "R2", "opcode when both bits set", {cap_o[2], cap_o[3]}, 2);
    rd(DATA, v);
    chk(v == 16'h3C5A, "R2", "read result when both bits set", v, 16'h3C5A);

    // R7: writes while busy are ignored
    wr(SELF, 16'(3 << 9));
    wr(DATA, 16'h1234);
    arm(64, 16'h0);
    wr(CMD, 16'h4000 | 16'(5'd2 << 5) | 16'd4);
    repeat (10) @(negedge clk);
    wr(CMD, 16'h8000 | 16'(5'd31 << 5) | 16'd31);
    wr(DATA, 16'hFFFF);
    wr(SELF, 16'(10 << 9) | 16'h0100);
    wait_idle();
    chk(nr == 64, "R7", "single frame despite busy command write", nr, 64);
    rd(CMD, v);
    chk(v == (16'h4000 | 16'(5'd2 << 5) | 16'd4), "R7", "command kept", v, 16'h4000 | 16'(5'd2 << 5) | 16'd4);
    rd(DATA, v);
    chk(v == 16'h1234, "R7", "data kept", v, 16'h1234);
    rd(SELF, v);
    chk(v == 16'(3 << 9), "R7", "self-control kept", v, 3 << 9);

    // R8: soft reset mid-read
    wr(SELF, 16'(5 << 9));
    arm(64, 16'hBEEF);
    wr(CMD, 16'h8000 | 16'(5'd1 << 5) | 16'd1);
    repeat (30) @(negedge clk);
    wr(SELF, 16'h0001);
    rd(SELF, v);
    chk(v[0] == 1'b1, "R8", "reset bit just after write", v[0], 1);
    @(negedge clk);
    rd(STAT, v);
    chk(v == 16'h0, "R8", "busy cleared by reset", v, 0);
    chk(!mdc && !mdio_oe, "R8", "mdc/oe during reset", {mdc, mdio_oe}, 0);
    wr(DATA, 16'h5555);
    repeat (5) @(negedge clk);
    rd(SELF, v);
    chk(v[0] == 1'b1, "R8", "reset bit on last reset cycle", v[0], 1);
    @(negedge clk);
    rd(SELF, v);
    chk(v == 16'h0, "R8", "self-control after reset", v, 0);
    rd(DATA, v);
    chk(v == 16'h0, "R8", "data cleared, write in reset ignored", v, 0);
    rd(CMD, v);
    chk(v == 16'h0, "R8", "command cleared", v, 0);

    // after reset a frame runs with the divider field at 0
    txn(1'b0, 5'd17, 5'd2, 16'h00FF, 1'b0, 0);

    summary();
    $finish;
  end
endmodule